// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Controller

This block turns a frame payload, handed over one byte at a time on a valid/ready stream, into a nibble stream on an MII-style transmit interface. It supplies the preamble and start delimiter itself. It pads payloads shorter than 60 bytes with zero bytes and appends a CRC-32 frame check sequence. One clock cycle is one nibble time, which is four bit times.

In half-duplex mode the block follows CSMA/CD. It holds off while carrier sense is high and keeps an interframe gap. When a collision occurs mid-frame it sends a jam pattern, then waits a random number of slot times and resends the frame. After 16 attempts it gives up and reports an abort. The payload is captured once into a local buffer, so every retry replays the same bytes. When `full_duplex` is high, carrier sense and collision are disregarded.

Back-pressure rules: `in_ready` is high only while the block is collecting a frame. A byte moves on any cycle with `in_valid` and `in_ready` both high, and the byte carrying `in_last` closes the frame. `in_ready` then stays low until the frame ends with `tx_done` or `tx_abort`. The source may hold `in_valid` low for any number of cycles between bytes. Bytes beyond `BUF_DEPTH` are accepted but dropped.

Top module: `eth_hdx_tx`

## Requirements
- R1: Every transmission attempt starts with 16 nibbles while `mii_tx_en` is high: fifteen of value 0x5 followed by one of value 0xD. Every byte after them goes out low nibble first.
- R2: The payload bytes follow the preamble in the order they were received. A payload shorter than 60 bytes is extended with 0x00 bytes to exactly 60 bytes; a longer payload is sent unpadded.
- R3: After the data comes the CRC-32 over data and padding: reflected polynomial 0xEDB88320, register preset to all ones, result inverted. It is sent as 8 nibbles, least significant nibble first. `mii_tx_en` then falls, and `tx_done` pulses for one cycle, in the first cycle it is low.
- R4: `in_ready` is high only while collecting. It is low from the cycle after the last byte is accepted until the frame completes or aborts. `mii_tx_en` is never high while `in_ready` is high.
- R5: Before any attempt, `mii_tx_en` has been low for at least `IFG_NIB` (24) cycles.
- R6: In half duplex no attempt starts while `mii_crs` is high. Once it falls, the start comes between `IFG_NIB` and `IFG_NIB`+3 cycles later.
- R7: In half duplex, a cycle with `mii_col` high during preamble, data or FCS is followed by exactly `JAM_NIB` (8) cycles of `mii_txd` = 0xA with `mii_tx_en` high. `mii_tx_en` then falls.
- R8: After the n-th jam the block waits r slots of `SLOT_NIB` cycles, with r in 0 to 2^min(n,`BACKOFF_CAP`)-1, and keeps the interframe gap. It then resends the whole frame from the preamble, identical to the first attempt.
- R9: If the `ATTEMPT_MAX`-th (16th) attempt also collides, `tx_abort` pulses for one cycle when its jam ends. No `tx_done` follows, and the block returns to collecting.
- R10: With `full_duplex` high, `mii_crs` and `mii_col` have no effect: the frame goes out unchanged and no jam occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Block accepts a payload byte |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex CSMA/CD |
| mii_crs | input | 1 | Carrier sense |
| mii_col | input | 1 | Collision detect |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: frame dropped after too many collisions |

## Verification
The framer is driven with a 10-byte payload, an exact 60-byte payload and an 80-byte payload. These tell apart padding that is missing, padding that is always applied, and an off-by-one at the pad boundary, and each CRC is checked against an independent bytewise model. Back-to-back one-byte frames separate gap enforcement from the collecting latency. A held carrier separates deferral from a plain gap. A single mid-frame collision checks the jam length, the backoff window and that the replayed frame is identical. A collision on every attempt checks the attempt limit. A full-duplex run with carrier and collision held high shows that the CSMA/CD logic is bypassed.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    S_LOAD,
    S_WAIT,
    S_PRE,
    S_DATA,
    S_FCS,
    S_JAM,
    S_BACKOFF
  } tx_state_e;

  localparam logic [3:0]  PRE_NIBBLE = 4'h5;
  localparam logic [3:0]  SFD_HI     = 4'hD;
  localparam logic [3:0]  JAM_NIBBLE = 4'hA;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

  // Reflected CRC-32 advanced by four bits, LSB of the nibble first.
  function automatic logic [31:0] crc_nib(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 4; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_frame_buf.sv
module eth_tx_frame_buf #(
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/eth_tx_gap.sv
module eth_tx_gap #(
  parameter int IFG_NIB = 24,
  localparam int GW     = $clog2(IFG_NIB + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,   // line driven by this block
  input  logic hold,     // carrier seen in half duplex
  output logic gap_ok
);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (active || hold)     cnt <= '0;
    else if (cnt != GW'(IFG_NIB)) cnt <= cnt + GW'(1);
  end

  assign gap_ok = (cnt == GW'(IFG_NIB)) && !hold;

endmodule

// File: rtl/eth_tx_backoff.sv
module eth_tx_backoff #(
  parameter int          SLOT_NIB = 128,
  parameter int          CAP      = 10,
  parameter int          ATW      = 5,
  parameter logic [15:0] SEED     = 16'hACE1,
  localparam int         TW       = (SLOT_NIB > 1) ? $clog2(SLOT_NIB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [ATW-1:0] expo,
  output logic           busy
);

  logic [15:0]    lfsr;
  logic [CAP-1:0] mask;
  logic [CAP-1:0] slots_left;
  logic [TW-1:0]  tick;

  // Free-running maximal-length LFSR, taps 16,14,13,11.
  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // Truncated exponent: bit i of the draw is kept when i < min(expo, CAP).
  always_comb begin
    for (int i = 0; i < CAP; i++) mask[i] = (i < int'(expo));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots_left <= '0;
      tick       <= '0;
    end else if (start) begin
      slots_left <= lfsr[CAP-1:0] & mask;
      tick       <= '0;
    end else if (slots_left != '0) begin
      if (tick == TW'(SLOT_NIB - 1)) begin
        tick       <= '0;
        slots_left <= slots_left - CAP'(1);
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  assign busy = (slots_left != '0);

endmodule

// File: rtl/eth_hdx_tx.sv
module eth_hdx_tx
  import eth_tx_pkg::*;
#(
  parameter int          BUF_DEPTH   = 256,
  parameter int          MIN_DATA    = 60,
  parameter int          IFG_NIB     = 24,
  parameter int          JAM_NIB     = 8,
  parameter int          SLOT_NIB    = 128,
  parameter int          ATTEMPT_MAX = 16,
  parameter int          BACKOFF_CAP = 10,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       full_duplex,
  input  logic       mii_crs,
  input  logic       mii_col,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       tx_done,
  output logic       tx_abort
);

  localparam int AW  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int LW  = $clog2(BUF_DEPTH + MIN_DATA + 1);
  localparam int CW  = $clog2(JAM_NIB + 16);
  localparam int ATW = $clog2(ATTEMPT_MAX + 1);

  tx_state_e      state;
  logic [LW-1:0]  len;
  logic [LW-1:0]  idx;
  logic           half;
  logic [CW-1:0]  cnt;
  logic [31:0]    crc;
  logic [ATW-1:0] attempts;
  logic           done_q, abort_q;

  logic [7:0]     rd_byte, byte_val;
  logic [LW-1:0]  pad_len;
  logic [3:0]     data_nib, fcs_nib;
  logic [31:0]    fcs_word;
  logic           wr_en, col_hit, jam_last, bo_start, bo_busy, gap_ok, sending;
  logic [ATW-1:0] bo_expo;

  // ---- payload store ----
  assign wr_en = in_valid && (state == S_LOAD) && (len < LW'(BUF_DEPTH));

  eth_tx_frame_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (len[AW-1:0]),
    .wdata (in_data),
    .raddr (idx[AW-1:0]),
    .rdata (rd_byte)
  );

  // ---- frame shaping ----
  assign byte_val = (idx < len) ? rd_byte : 8'h00;
  assign pad_len  = (len < LW'(MIN_DATA)) ? LW'(MIN_DATA) : len;
  assign data_nib = half ? byte_val[7:4] : byte_val[3:0];
  assign fcs_word = ~crc;
  assign fcs_nib  = fcs_word[{cnt[2:0], 2'b00} +: 4];

  assign sending   = (state == S_PRE) || (state == S_DATA) || (state == S_FCS);
  assign mii_tx_en = sending || (state == S_JAM);
  assign in_ready  = (state == S_LOAD);
  assign tx_done   = done_q;
  assign tx_abort  = abort_q;

  always_comb begin
    unique case (state)
      S_PRE:   mii_txd = (cnt == CW'(15)) ? SFD_HI : PRE_NIBBLE;
      S_DATA:  mii_txd = data_nib;
      S_FCS:   mii_txd = fcs_nib;
      S_JAM:   mii_txd = JAM_NIBBLE;
      default: mii_txd = 4'h0;
    endcase
  end

  // ---- CSMA/CD support ----
  assign col_hit  = sending && mii_col && !full_duplex;
  assign jam_last = (state == S_JAM) && (cnt == CW'(JAM_NIB - 1));
  assign bo_start = jam_last && (attempts != ATW'(ATTEMPT_MAX - 1));
  assign bo_expo  = attempts + ATW'(1);

  eth_tx_gap #(.IFG_NIB(IFG_NIB)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (mii_tx_en),
    .hold   (!full_duplex && mii_crs),
    .gap_ok (gap_ok)
  );

  eth_tx_backoff #(
    .SLOT_NIB (SLOT_NIB),
    .CAP      (BACKOFF_CAP),
    .ATW      (ATW),
    .SEED     (LFSR_SEED)
  ) u_backoff (
    .clk   (clk),
    .rst_n (rst_n),
    .start (bo_start),
    .expo  (bo_expo),
    .busy  (bo_busy)
  );

  // ---- sequencer ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_LOAD;
      len      <= '0;
      idx      <= '0;
      half     <= 1'b0;
      cnt      <= '0;
      crc      <= '1;
      attempts <= '0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (col_hit) begin
        state <= S_JAM;
        cnt   <= '0;
      end else begin
        unique case (state)
          S_LOAD: begin
            if (in_valid) begin
              if (wr_en) len <= len + LW'(1);
              if (in_last) begin
                state    <= S_WAIT;
                attempts <= '0;
              end
            end
          end
          S_WAIT: begin
            if (gap_ok) begin
              state <= S_PRE;
              cnt   <= '0;
              idx   <= '0;
              half  <= 1'b0;
              crc   <= '1;
            end
          end
          S_PRE: begin
            if (cnt == CW'(15)) state <= S_DATA;
            else                cnt   <= cnt + CW'(1);
          end
          S_DATA: begin
            crc  <= crc_nib(crc, data_nib);
            half <= ~half;
            if (half) begin
              idx <= idx + LW'(1);
              if ((idx + LW'(1)) == pad_len) begin
                state <= S_FCS;
                cnt   <= '0;
              end
            end
          end
          S_FCS: begin
            if (cnt == CW'(7)) begin
              state  <= S_LOAD;
              len    <= '0;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          S_JAM: begin
            if (jam_last) begin
              if (bo_start) begin
                attempts <= attempts + ATW'(1);
                state    <= S_BACKOFF;
              end else begin
                state   <= S_LOAD;
                len     <= '0;
                abort_q <= 1'b1;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          S_BACKOFF: begin
            if (!bo_busy) state <= S_WAIT;
          end
          default: state <= S_LOAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/eth_hdx_tx_chk.sv
module eth_hdx_tx_chk
  import eth_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       full_duplex,
  input logic       mii_crs,
  input logic       mii_col,
  input logic [3:0] mii_txd,
  input logic       mii_tx_en,
  input logic       tx_done,
  input logic       tx_abort,
  input tx_state_e  st
);

  // R4: never transmitting while collecting
  a_r4_no_tx_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mii_tx_en);

  // R6: a half-duplex start never follows a sampled carrier
  a_r6_no_start_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mii_tx_en) && !$past(full_duplex)) |-> !$past(mii_crs));

  // R7: collision during frame leads to jam on the next cycle
  a_r7_jam_follows_collision: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PRE || st == S_DATA || st == S_FCS) && mii_col && !full_duplex)
      |=> (st == S_JAM && mii_tx_en && mii_txd == JAM_NIBBLE));

  // R10: full duplex never enters jam
  a_r10_full_duplex_no_jam: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && st != S_JAM) |=> (st != S_JAM));

  // R3: done marks the first idle cycle after a frame
  a_r3_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!mii_tx_en && $past(mii_tx_en)));

  // R9: abort comes straight out of a jam
  a_r9_abort_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> ($past(st) == S_JAM && !mii_tx_en));

  // R9: done and abort are exclusive
  a_r9_exclusive_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_abort));

endmodule

bind eth_hdx_tx eth_hdx_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .full_duplex (full_duplex),
  .mii_crs     (mii_crs),
  .mii_col     (mii_col),
  .mii_txd     (mii_txd),
  .mii_tx_en   (mii_tx_en),
  .tx_done     (tx_done),
  .tx_abort    (tx_abort),
  .st          (state)
);

// File: tb/eth_hdx_tx_tb.sv
module eth_hdx_tx_tb;

  localparam int IFG  = 24;
  localparam int JAM  = 8;
  localparam int SLOT = 4;
  localparam int CAP  = 6;
  localparam int ATT  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       full_duplex = 1'b0;
  logic       mii_crs = 1'b0;
  logic       mii_col = 1'b0;
  logic [3:0] mii_txd;
  logic       mii_tx_en;
  logic       tx_done;
  logic       tx_abort;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] dat [0:255];
  int         dlen;
  logic [3:0] got [0:2047];
  int         low_run = 0;
  int         last_gap = 0;

  eth_hdx_tx #(
    .SLOT_NIB    (SLOT),
    .BACKOFF_CAP (CAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .full_duplex(full_duplex),
    .mii_crs(mii_crs), .mii_col(mii_col), .mii_txd(mii_txd),
    .mii_tx_en(mii_tx_en), .tx_done(tx_done), .tx_abort(tx_abort)
  );

  always #2 clk = ~clk;

  // Length of the low stretch before each rise of tx_en.
  always @(negedge clk) begin
    if (mii_tx_en) begin
      if (low_run > 0) last_gap = low_run;
      low_run = 0;
    end else begin
      low_run++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      b = (i < dlen) ? dat[i] : 8'h00;
      for (int k = 0; k < 8; k++) begin
        if ((c[0] ^ b[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
        else                       c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic feed(input int len, input int seed);
    dlen = len;
    for (int i = 0; i < len; i++) dat[i] = 8'((seed + i * 37 + (i >> 3)) & 8'hFF);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = dat[i];
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(!in_ready, "R4", "in_ready low after last byte", in_ready, 0);
  endtask

  // Capture one burst of tx_en. col_at >= 0 pulses collision at that nibble.
  task automatic grab(input int col_at, output int n, output bit dn,
                      output bit ab, output int gap);
    int w;
    bit rdy_bad;
    w = 0; n = 0; dn = 0; ab = 0; gap = -1; rdy_bad = 0;
    @(negedge clk);
    while (!mii_tx_en && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (!mii_tx_en) return;
    #1;
    gap = last_gap;
    while (mii_tx_en) begin
      got[n] = mii_txd;
      if (in_ready) rdy_bad = 1;
      if (col_at >= 0) mii_col = (n == col_at);
      n++;
      @(negedge clk);
    end
    if (col_at >= 0) mii_col = 1'b0;
    dn = tx_done;
    ab = tx_abort;
    chk(!rdy_bad, "R4", "in_ready low while transmitting", rdy_bad, 0);
  endtask

  task automatic check_frame(input int n);
    int pl, total, bad, first_bad;
    logic [31:0] f;
    logic [3:0]  e;
    logic [7:0]  b;
    pl = (dlen < 60) ? 60 : dlen;
    total = 16 + 2 * pl + 8;
    chk(n == total, "R2", "frame length in nibbles", n, total);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 16 && i < n; i++) begin
      e = (i == 15) ? 4'hD : 4'h5;
      if (got[i] !== e) begin bad++; if (first_bad < 0) first_bad = i; end
    end
    chk(bad == 0, "R1", "preamble nibble errors", bad, 0);
    bad = 0;
    for (int i = 0; i < 2 * pl && 16 + i < n; i++) begin
      b = ((i >> 1) < dlen) ? dat[i >> 1] : 8'h00;
      e = i[0] ? b[7:4] : b[3:0];
      if (got[16 + i] !== e) bad++;
    end
    chk(bad == 0, "R2", "data/pad nibble errors", bad, 0);
    f = ref_fcs(pl);
    bad = 0;
    for (int i = 0; i < 8 && 16 + 2 * pl + i < n; i++)
      if (got[16 + 2 * pl + i] !== f[4 * i +: 4]) bad++;
    chk(bad == 0, "R3", "FCS nibble errors", bad, 0);
  endtask

  task automatic check_jam(input int n, input int col_at);
    int bad;
    chk(n == col_at + 1 + JAM, "R7", "nibbles up to end of jam", n, col_at + 1 + JAM);
    bad = 0;
    for (int i = col_at + 1; i < n; i++) if (got[i] !== 4'hA) bad++;
    chk(bad == 0, "R7", "jam nibble errors", bad, 0);
  endtask

  task automatic t_reset;
    chk(mii_tx_en == 1'b0, "R4", "tx_en after reset", mii_tx_en, 0);
    chk(in_ready == 1'b1, "R4", "in_ready after reset", in_ready, 1);
    chk(!tx_done && !tx_abort, "R3", "status after reset", tx_done | tx_abort, 0);
  endtask

  // R1 R2 R3 R10: short frame padded, carrier and collision held high in full duplex
  task automatic t_short_full;
    int n, gap; bit dn, ab;
    full_duplex = 1'b1; mii_crs = 1'b1; mii_col = 1'b1;
    feed(10, 3);
    grab(-1, n, dn, ab, gap);
    check_frame(n);
    chk(dn, "R10", "done despite crs/col in full duplex", dn, 1);
    mii_crs = 1'b0; mii_col = 1'b0;
  endtask

  task automatic t_len(input int len, input int seed);
    int n, gap; bit dn, ab;
    full_duplex = 1'b0;
    feed(len, seed);
    grab(-1, n, dn, ab, gap);
    check_frame(n);
    chk(dn && !ab, "R3", "done pulse on frame end", dn, 1);
  endtask

  // R5: back-to-back minimal frames
  task automatic t_backtoback;
    int n, gap; bit dn, ab;
    full_duplex = 1'b1;
    feed(1, 90);
    grab(-1, n, dn, ab, gap);
    check_frame(n);
    feed(1, 91);
    grab(-1, n, dn, ab, gap);
    check_frame(n);
    chk(gap >= IFG && gap <= IFG + 4, "R5", "gap between frames", gap, IFG);
  endtask

  // R6: deferral on carrier
  task automatic t_defer;
    int n, gap, wait_c; bit dn, ab, early;
    full_duplex = 1'b0;
    mii_crs = 1'b1;
    feed(20, 7);
    early = 0;
    repeat (120) begin
      @(negedge clk);
      if (mii_tx_en) early = 1;
    end
    chk(!early, "R6", "no start while carrier high", early, 0);
    mii_crs = 1'b0;
    wait_c = 0;
    while (!mii_tx_en && wait_c < 500) begin
      @(negedge clk);
      wait_c++;
    end
    chk(wait_c >= IFG && wait_c <= IFG + 3, "R6", "start delay after carrier drop", wait_c, IFG + 1);
    grab(-1, n, dn, ab, gap);
    chk(n == 16 + 120 + 8 - 1, "R6", "rest of deferred frame", n, 16 + 120 + 8 - 1);
  endtask

  // R7 R8: single collision then replay
  task automatic t_retry;
    int n, gap; bit dn, ab;
    full_duplex = 1'b0;
    feed(70, 11);
    grab(30, n, dn, ab, gap);
    check_jam(n, 30);
    chk(!dn && !ab, "R7", "no status after first jam", dn | ab, 0);
    grab(-1, n, dn, ab, gap);
    chk(gap >= IFG && gap <= IFG + SLOT + 4, "R8", "retry gap", gap, IFG);
    check_frame(n);
    chk(dn, "R8", "retry completes", dn, 1);
  endtask

  // R9: collision on every attempt
  task automatic t_excess;
    int n, gap, tries, lim, expo; bit dn, ab, any_done, gap_bad;
    full_duplex = 1'b0;
    feed(20, 55);
    tries = 0; any_done = 0; gap_bad = 0; ab = 0;
    for (int a = 0; a < ATT + 4; a++) begin
      grab(10, n, dn, ab, gap);
      if (n == 0) break;
      tries++;
      if (dn) any_done = 1;
      if (a > 0) begin
        expo = (a < CAP) ? a : CAP;
        lim  = IFG + ((1 << expo) - 1) * SLOT + 4;
        if (gap < IFG || gap > lim) gap_bad = 1;
      end
      if (a == ATT - 1) check_jam(n, 10);
      if (ab) break;
    end
    chk(tries == ATT, "R9", "attempts before abort", tries, ATT);
    chk(ab, "R9", "abort pulse", ab, 1);
    chk(!any_done, "R9", "no done on aborted frame", any_done, 0);
    chk(!gap_bad, "R8", "backoff gaps in window", gap_bad, 0);
    chk(in_ready, "R9", "collecting again after abort", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_full();
    t_len(60, 21);
    t_len(80, 42);
    t_backtoback();
    t_defer();
    t_retry();
    t_excess();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule